// File: doc/BRIEF.md
# Transmit FIFO Start-Threshold Gate

This block sits between a transmit FIFO and the MAC that serialises frames out of it. It decides when the MAC may begin draining the current frame. When a frame first shows up in the FIFO, the block captures a start threshold from two configuration fields. It then raises a start permit once enough bytes of that frame are buffered. In store-and-forward mode it instead waits until the whole frame has been written.

During transmission the block watches the MAC's read strobe. If the MAC asks for a byte while the FIFO is empty and the frame's last byte has not yet been written, it records an underflow. On an underflow it sets a status bit, pulses an interrupt bit and switches the transmitter off. Software can then see the transmitter-enable state fall, raise the threshold by one code step and re-enable. Because the threshold is captured once per frame, a change made during a frame takes effect only at the next frame start.

Top module: `txfifo_start_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, start_ok, tx_on, ufl_status and every bit of irq_bits are 0.
- R2: A nonzero bus-control threshold code (bits 5:3 of the bus-control byte) takes precedence over the other field. Codes 1 to 5 give thresholds of 64, 128, 256, 512 and 1024 bytes. start_ok stays low while fifo_level is below the threshold. It goes high one cycle after fifo_level reaches the threshold.
- R3: When the bus-control code is 0, the transmit-config code (bits 7:5 of the transmit-config byte) selects the threshold. Codes 0 to 3 give 128, 256, 512 and 1024 bytes, with the same timing as R2.
- R4: Store-and-forward applies for bus-control codes 6 and 7, and for transmit-config codes 4 to 7 when the bus-control code is 0. In that mode start_ok stays low at any fill level until eof_buffered is seen, and rises one cycle after it.
- R5: In threshold mode, eof_buffered also grants start_ok one cycle later, even if fifo_level is below the threshold.
- R6: The threshold is captured at the frame start, which is the first cycle in which the transmitter is on, the block is idle and the FIFO holds data or an end marker. A change to either code after that does not affect the current frame. It applies from the next frame start.
- R7: Underflow occurs when mac_rd is high while start_ok is high, fifo_level is 0 and eof_buffered is low. On the next cycle ufl_status is 1, irq_bits equals 16'h0200 (bit 9 only) and start_ok is 0. The interrupt bit lasts exactly one cycle. mac_rd at fifo_level 0 with eof_buffered high is not an underflow.
- R8: An underflow clears tx_on. While tx_on is 0, start_ok stays 0 whatever the FIFO shows. A tx_en_req pulse sets tx_on again one cycle later.
- R9: ufl_status holds its value until the next frame start, at which it clears.
- R10: If an underflow and tx_en_req happen in the same cycle, the underflow wins and tx_on is 0 afterwards.
- R11: mac_rd_last during transmission ends the frame. start_ok is 0 on the next cycle, and the next frame must meet its own threshold again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_thr_code | input | 3 | Primary threshold code (bus-control bits 5:3) |
| txc_thr_code | input | 3 | Fallback threshold code (transmit-config bits 7:5) |
| fifo_level | input | LVL_W (11) | Bytes of the current frame held in the FIFO |
| eof_buffered | input | 1 | End-of-frame marker present in the FIFO |
| mac_rd | input | 1 | MAC byte read strobe |
| mac_rd_last | input | 1 | MAC read of the frame's final byte |
| tx_en_req | input | 1 | Software pulse that turns the transmitter on |
| start_ok | output | 1 | MAC may drain the current frame |
| ufl_status | output | 1 | Per-frame underflow status |
| irq_bits | output | IRQ_W (16) | Interrupt word; bit 9 pulses on underflow |
| tx_on | output | 1 | Transmitter enable state |

## Verification
Two events can coincide in one cycle: an underflow, which switches the transmitter off, and a software enable request, which switches it on. The bench reaches transmission, then asserts tx_en_req in the same cycle as an underflowing MAC read. It then checks that tx_on reads 0 and the interrupt bit fires. A second overlap is a configuration write arriving in the cycle after frame start. The bench judges it by whether the old or the new threshold governs the permit.

// File: rtl/txsg_pkg.sv
package txsg_pkg;

    localparam int THR_W     = 11;
    localparam int BUS_BASE  = 64;
    localparam int TXC_BASE  = 128;
    localparam int BUS_MAXC  = 5;
    localparam int TXC_MAXC  = 3;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } gate_st_e;

    typedef struct packed {
        logic             saf;
        logic [THR_W-1:0] bytes;
    } thr_t;

    function automatic thr_t pick_thr(input logic [2:0] bus_c,
                                      input logic [2:0] txc_c);
        thr_t r;
        r.saf   = 1'b0;
        r.bytes = '0;
        if (bus_c != 3'd0) begin
            if (int'(bus_c) <= BUS_MAXC)
                r.bytes = THR_W'(BUS_BASE) << (bus_c - 3'd1);
            else
                r.saf = 1'b1;
        end else begin
            if (int'(txc_c) <= TXC_MAXC)
                r.bytes = THR_W'(TXC_BASE) << txc_c;
            else
                r.saf = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/txsg_thr_select.sv
module txsg_thr_select
    import txsg_pkg::*;
#(
    parameter int LVL_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_en,
    input  logic [2:0]       bus_code,
    input  logic [2:0]       txc_code,
    input  logic [LVL_W-1:0] level,
    input  logic             eof_in,
    output logic             thr_saf,
    output logic             go
);
    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    thr_t thr_q;
    thr_t thr_d;

    always_comb thr_d = pick_thr(bus_code, txc_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q.saf   <= 1'b1;
            thr_q.bytes <= '0;
        end else if (latch_en) begin
            thr_q <= thr_d;
        end
    end

    logic enough;
    always_comb enough = CMP_W'(level) >= CMP_W'(thr_q.bytes);

    always_comb begin
        if (thr_q.saf) go = eof_in;
        else           go = eof_in || enough;
    end

    assign thr_saf = thr_q.saf;

    // R6
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(latch_en) |-> $stable(thr_q));

endmodule

// File: rtl/txsg_gate_fsm.sv
module txsg_gate_fsm
    import txsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_en_req,
    input  logic frame_seen,
    input  logic go,
    input  logic mac_rd,
    input  logic mac_rd_last,
    input  logic fifo_empty,
    input  logic eof_in,
    output logic start_ok,
    output logic tx_on,
    output logic frame_start,
    output logic ufl_hit
);
    gate_st_e st_q, st_d;

    always_comb begin
        frame_start = (st_q == ST_IDLE) && frame_seen;
        ufl_hit     = (st_q == ST_SEND) && mac_rd && fifo_empty && !eof_in;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (tx_en_req)   st_d = ST_IDLE;
            ST_IDLE: if (frame_seen)  st_d = ST_WAIT;
            ST_WAIT: if (go)          st_d = ST_SEND;
            ST_SEND: begin
                if (ufl_hit)          st_d = ST_HALT;
                else if (mac_rd_last) st_d = ST_IDLE;
            end
            default:                  st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_HALT;
        else     st_q <= st_d;
    end

    assign start_ok = (st_q == ST_SEND);
    assign tx_on    = (st_q != ST_HALT);

    // R8
    no_start_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_on && !tx_en_req) |=> !start_ok);

    // R11
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (start_ok && mac_rd_last && !ufl_hit) |=> !start_ok);

endmodule

// File: rtl/txsg_ufl_report.sv
module txsg_ufl_report #(
    parameter int IRQ_W   = 16,
    parameter int UFL_BIT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ufl_hit,
    input  logic             frame_start,
    output logic             ufl_status,
    output logic [IRQ_W-1:0] irq_bits
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ufl_status <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= ufl_hit;
            if (ufl_hit)          ufl_status <= 1'b1;
            else if (frame_start) ufl_status <= 1'b0;
        end
    end

    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
        if (i == UFL_BIT) begin : g_ufl
            assign irq_bits[i] = irq_q;
        end else begin : g_zero
            assign irq_bits[i] = 1'b0;
        end
    end

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_start) && !$past(ufl_hit)) |-> !ufl_status);

endmodule

// File: rtl/txfifo_start_gate.sv
module txfifo_start_gate #(
    parameter int LVL_W   = 11,
    parameter int IRQ_W   = 16,
    parameter int UFL_BIT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       bus_thr_code,
    input  logic [2:0]       txc_thr_code,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             eof_buffered,
    input  logic             mac_rd,
    input  logic             mac_rd_last,
    input  logic             tx_en_req,
    output logic             start_ok,
    output logic             ufl_status,
    output logic [IRQ_W-1:0] irq_bits,
    output logic             tx_on
);
    logic fifo_empty, frame_seen, go, thr_saf, frame_start, ufl_hit;

    assign fifo_empty = (fifo_level == '0);
    assign frame_seen = !fifo_empty || eof_buffered;

    txsg_thr_select #(.LVL_W(LVL_W)) u_thr (
        .clk      (clk),
        .rst      (rst),
        .latch_en (frame_start),
        .bus_code (bus_thr_code),
        .txc_code (txc_thr_code),
        .level    (fifo_level),
        .eof_in   (eof_buffered),
        .thr_saf  (thr_saf),
        .go       (go)
    );

    txsg_gate_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tx_en_req   (tx_en_req),
        .frame_seen  (frame_seen),
        .go          (go),
        .mac_rd      (mac_rd),
        .mac_rd_last (mac_rd_last),
        .fifo_empty  (fifo_empty),
        .eof_in      (eof_buffered),
        .start_ok    (start_ok),
        .tx_on       (tx_on),
        .frame_start (frame_start),
        .ufl_hit     (ufl_hit)
    );

    txsg_ufl_report #(.IRQ_W(IRQ_W), .UFL_BIT(UFL_BIT)) u_rep (
        .clk         (clk),
        .rst         (rst),
        .ufl_hit     (ufl_hit),
        .frame_start (frame_start),
        .ufl_status  (ufl_status),
        .irq_bits    (irq_bits)
    );

    // R4
    saf_needs_eof_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(start_ok) && thr_saf) |-> $past(eof_buffered));

    // R7
    ufl_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        irq_bits[UFL_BIT] |-> (!tx_on && !start_ok && ufl_status));

endmodule

// File: tb/txfifo_start_gate_bench.sv
`timescale 1ns/1ps
module txfifo_start_gate_bench;

    typedef struct packed {
        logic [2:0]  bus;
        logic [2:0]  txc;
        logic [11:0] thr;
        logic        saf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd0, 12'd64,   1'b0},
        '{3'd2, 3'd0, 12'd128,  1'b0},
        '{3'd3, 3'd0, 12'd256,  1'b0},
        '{3'd4, 3'd0, 12'd512,  1'b0},
        '{3'd5, 3'd0, 12'd1024, 1'b0},
        '{3'd7, 3'd0, 12'd0,    1'b1},
        '{3'd6, 3'd0, 12'd0,    1'b1},
        '{3'd0, 3'd0, 12'd128,  1'b0},
        '{3'd0, 3'd1, 12'd256,  1'b0},
        '{3'd0, 3'd2, 12'd512,  1'b0},
        '{3'd0, 3'd3, 12'd1024, 1'b0},
        '{3'd0, 3'd4, 12'd0,    1'b1},
        '{3'd0, 3'd7, 12'd0,    1'b1},
        '{3'd1, 3'd7, 12'd64,   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_thr_code = 3'd0;
    logic [2:0]  txc_thr_code = 3'd0;
    logic [10:0] fifo_level = '0;
    logic        eof_buffered = 1'b0;
    logic        mac_rd = 1'b0;
    logic        mac_rd_last = 1'b0;
    logic        tx_en_req = 1'b0;
    logic        start_ok, ufl_status, tx_on;
    logic [15:0] irq_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txfifo_start_gate u_txfifo_start_gate (
        .clk          (clk),
        .rst          (rst),
        .bus_thr_code (bus_thr_code),
        .txc_thr_code (txc_thr_code),
        .fifo_level   (fifo_level),
        .eof_buffered (eof_buffered),
        .mac_rd       (mac_rd),
        .mac_rd_last  (mac_rd_last),
        .tx_en_req    (tx_en_req),
        .start_ok     (start_ok),
        .ufl_status   (ufl_status),
        .irq_bits     (irq_bits),
        .tx_on        (tx_on)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.saf)               return "R4 store-and-forward";
        else if (v.bus == 3'd0)  return "R3 fallback code";
        else                     return "R2 primary code";
    endfunction

    task automatic end_frame();
        mac_rd_last  = 1'b1;
        fifo_level   = '0;
        eof_buffered = 1'b0;
        tick();
        mac_rd_last  = 1'b0;
        chk({15'd0, start_ok}, 16'd0, "R11 permit drops at frame end");
        tick();
    endtask

    task automatic begin_frame();
        fifo_level = 11'd1;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        chk({15'd0, start_ok}, 16'd0, "R1 start_ok in reset");
        chk({15'd0, tx_on},    16'd0, "R1 tx_on in reset");
        rst = 1'b0;
        tick();
        chk({13'd0, start_ok, tx_on, ufl_status}, 16'd0, "R1 after reset");
        chk(irq_bits, 16'd0, "R1 irq after reset");

        tx_en_req = 1'b1; tick(); tx_en_req = 1'b0;
        chk({15'd0, tx_on}, 16'd1, "R8 enable request");

        for (int i = 0; i < NV; i++) begin
            bus_thr_code = VECS[i].bus;
            txc_thr_code = VECS[i].txc;
            begin_frame();
            if (!VECS[i].saf) begin
                fifo_level = 11'(VECS[i].thr - 12'd1);
                tick(); tick(); tick();
                chk({15'd0, start_ok}, 16'd0, tag_of(VECS[i]));
                fifo_level = 11'(VECS[i].thr);
                tick();
                chk({15'd0, start_ok}, 16'd1, tag_of(VECS[i]));
            end else begin
                fifo_level = 11'd2000;
                tick(); tick(); tick();
                chk({15'd0, start_ok}, 16'd0, tag_of(VECS[i]));
                eof_buffered = 1'b1;
                tick();
                chk({15'd0, start_ok}, 16'd1, tag_of(VECS[i]));
            end
            end_frame();
        end

        // R5: short frame released by end marker
        bus_thr_code = 3'd3; txc_thr_code = 3'd0;
        begin_frame();
        fifo_level = 11'd10; eof_buffered = 1'b1;
        tick();
        chk({15'd0, start_ok}, 16'd1, "R5 end marker releases short frame");
        end_frame();

        // R6: threshold held for the frame
        bus_thr_code = 3'd1;
        begin_frame();
        bus_thr_code = 3'd5;
        fifo_level = 11'd64;
        tick();
        chk({15'd0, start_ok}, 16'd1, "R6 old threshold kept mid-frame");
        end_frame();
        begin_frame();
        fifo_level = 11'd64;
        tick(); tick();
        chk({15'd0, start_ok}, 16'd0, "R6 new threshold at next frame");
        fifo_level = 11'd1024;
        tick();
        chk({15'd0, start_ok}, 16'd1, "R6 new threshold met");
        end_frame();

        // R7: empty read with end marker is not an underflow
        bus_thr_code = 3'd1;
        begin_frame();
        fifo_level = 11'd64; tick();
        fifo_level = '0; eof_buffered = 1'b1; mac_rd = 1'b1;
        tick();
        mac_rd = 1'b0;
        chk({14'd0, ufl_status, start_ok}, 16'd1, "R7 no underflow with end marker");
        chk(irq_bits, 16'd0, "R7 no irq with end marker");
        end_frame();

        // R7: real underflow
        begin_frame();
        fifo_level = 11'd64; tick();
        fifo_level = '0; mac_rd = 1'b1;
        tick();
        mac_rd = 1'b0;
        chk(irq_bits, 16'h0200, "R7 irq bit 9");
        chk({15'd0, ufl_status}, 16'd1, "R7 status set");
        chk({15'd0, start_ok}, 16'd0, "R7 permit dropped");
        chk({15'd0, tx_on}, 16'd0, "R8 transmitter off");
        tick();
        chk(irq_bits, 16'd0, "R7 irq one cycle");

        // R8: no start while off
        fifo_level = 11'd2000; eof_buffered = 1'b1;
        tick(); tick(); tick();
        chk({14'd0, tx_on, start_ok}, 16'd0, "R8 held off");
        fifo_level = '0; eof_buffered = 1'b0;
        tx_en_req = 1'b1; tick(); tx_en_req = 1'b0;
        chk({15'd0, tx_on}, 16'd1, "R8 re-enabled");
        chk({15'd0, ufl_status}, 16'd1, "R9 status held until frame start");
        begin_frame();
        chk({15'd0, ufl_status}, 16'd0, "R9 status cleared at frame start");

        // R10: underflow and enable request together
        fifo_level = 11'd64; tick();
        fifo_level = '0; mac_rd = 1'b1; tx_en_req = 1'b1;
        tick();
        mac_rd = 1'b0; tx_en_req = 1'b0;
        chk({15'd0, tx_on}, 16'd0, "R10 underflow wins");
        chk(irq_bits, 16'h0200, "R10 irq raised");
        tick();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule